// File: doc/BRIEF.md
# Spare Stream Status Stripper

This block sits on the spare-area byte path of a paged flash error-correction engine. On the engine side, every spare chunk in the stream is followed by a group of four status bytes. In strip mode the block drops those groups, so the spare bytes leave as one linear stream. It also keeps the first byte of each group in a small status array that can be read by chunk index. In insert mode it does the reverse: after every chunk of input bytes it appends four zero-valued status slots, which gives the engine the layout it expects.

Both sides are valid/ready byte streams. The chunk length and the number of chunks per page are runtime inputs. The chunk count is the page size divided by the 1 KiB data step, up to 16. These inputs and the mode must stay stable while a page is in progress. A page ends after the configured number of chunks, and the next page starts at once from chunk 0. No start command is needed. A single-cycle done pulse marks the end of each page.

Top module: `spare_status_shaper`

## Requirements
- R1: In strip mode (mode = 0), with chunk length L, the output stream is the input bytes at positions n*(L+4)+k for 0 <= k < L, in input order. n is the chunk index within the page.
- R2: In strip mode, the four bytes at positions n*(L+4)+L to n*(L+4)+L+3 are accepted on the input but never appear on the output.
- R3: In strip mode, the byte at input position n*(L+4)+L is stored as status entry n. With stat_idx = n, stat_byte shows that entry one clock later.
- R4: In insert mode (mode = 1), every L input bytes are output unchanged and then followed by four output bytes of value 0x00.
- R5: In insert mode, in_ready is low while the four zero slots of a chunk are being produced, so no input byte is consumed during them.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data is unchanged on the next clock.
- R7: In strip mode, done is high for exactly one clock, on the clock after the input handshake of the last status byte of chunk chunk_num-1.
- R8: In insert mode, done is high for exactly one clock, on the clock after the output handshake of the last zero slot of chunk chunk_num-1.
- R9: After a page ends, the next accepted byte is treated as position 0 of chunk 0 of a new page. The chunk count is the value of chunk_num (1 to 16).
- R10: During and right after reset, out_valid and done are low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = strip status groups, 1 = insert zero slots |
| chunk_len | input | LEN_W | Spare bytes per chunk (1 or more) |
| chunk_num | input | CNT_W | Chunks per page (1 to MAX_CHUNKS) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Block accepts the input byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Downstream accepts the output byte |
| done | output | 1 | One-clock end-of-page pulse |
| stat_idx | input | IDX_W | Status array read index |
| stat_byte | output | 8 | Status entry at stat_idx, one clock late |

## Verification
A wrong position or chunk counter shows up at once as a misplaced byte. In strip mode a status byte leaks into the output or a data byte goes missing. In insert mode a zero slot appears at the wrong spot, and the bench finds it at the very next output handshake. A chunk counter that is off by one moves the done pulse away from its expected clock at the end of the first page. It also stores status under the wrong index, which reading the array back one clock after each index is set will show. A lost or changed byte under backpressure shows on the clock after any stall.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int STAT_SLOTS = 4;
  typedef enum logic {
    SHAPE_STRIP  = 1'b0,
    SHAPE_INSERT = 1'b1
  } shape_mode_e;
endpackage

// File: rtl/sss_seq.sv
module sss_seq #(
  parameter int LEN_W = 8,
  parameter int CNT_W = 5,
  parameter int IDX_W = 4,
  localparam int POS_W = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [LEN_W-1:0] chunk_len,
  input  logic [CNT_W-1:0] chunk_num,
  output logic [POS_W-1:0] pos,
  output logic [IDX_W-1:0] chunk,
  output logic             in_data_zone,
  output logic             at_status_head,
  output logic             page_last
);
  import sss_pkg::*;

  logic [POS_W-1:0] len_ext;
  logic [POS_W-1:0] end_pos;
  logic             chunk_end;
  logic             last_chunk;

  assign len_ext        = {1'b0, chunk_len};
  assign end_pos        = len_ext + POS_W'(STAT_SLOTS - 1);
  assign in_data_zone   = pos < len_ext;
  assign at_status_head = pos == len_ext;
  assign chunk_end      = pos == end_pos;
  assign last_chunk     = (CNT_W'(chunk) + CNT_W'(1)) == chunk_num;
  assign page_last      = chunk_end && last_chunk;

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= '0;
      chunk <= '0;
    end else if (step) begin
      if (chunk_end) begin
        pos   <= '0;
        chunk <= last_chunk ? '0 : chunk + IDX_W'(1);
      end else begin
        pos <= pos + POS_W'(1);
      end
    end
  end
endmodule

// File: rtl/sss_ostage.sv
module sss_ostage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          load_last,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          out_last,
  output logic          free
);
  assign free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
    end
  end
endmodule

// File: rtl/sss_stat_ram.sv
module sss_stat_ram #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/spare_status_shaper.sv
module spare_status_shaper #(
  parameter int LEN_W      = 8,
  parameter int MAX_CHUNKS = 16,
  localparam int CNT_W     = $clog2(MAX_CHUNKS + 1),
  localparam int IDX_W     = $clog2(MAX_CHUNKS),
  localparam int POS_W     = LEN_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic [LEN_W-1:0] chunk_len,
  input  logic [CNT_W-1:0] chunk_num,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  output logic [7:0]       out_data,
  input  logic             out_ready,
  output logic             done,
  input  logic [IDX_W-1:0] stat_idx,
  output logic [7:0]       stat_byte
);
  import sss_pkg::*;

  shape_mode_e      md;
  logic [POS_W-1:0] pos;
  logic [IDX_W-1:0] chunk;
  logic             in_data_zone;
  logic             at_status_head;
  logic             page_last;
  logic             free;
  logic             out_last;
  logic             step;
  logic             load;
  logic             take;

  assign md   = shape_mode_e'(mode);
  assign take = in_valid && in_ready;

  always_comb begin
    if (md == SHAPE_STRIP) begin
      in_ready = free;
      step     = take;
      load     = take && in_data_zone;
    end else begin
      in_ready = free && in_data_zone;
      step     = in_data_zone ? take : free;
      load     = step;
    end
  end

  sss_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst(rst), .step(step), .chunk_len(chunk_len),
    .chunk_num(chunk_num), .pos(pos), .chunk(chunk),
    .in_data_zone(in_data_zone), .at_status_head(at_status_head),
    .page_last(page_last)
  );

  sss_ostage #(.DW(8)) u_out (
    .clk(clk), .rst(rst), .load(load),
    .load_data(in_data_zone ? in_data : 8'h00),
    .load_last(page_last && md == SHAPE_INSERT),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_last(out_last), .free(free)
  );

  sss_stat_ram #(.DEPTH(MAX_CHUNKS), .DW(8)) u_stat (
    .clk(clk), .we(md == SHAPE_STRIP && take && at_status_head),
    .waddr(chunk), .wdata(in_data), .raddr(stat_idx), .rdata(stat_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= (md == SHAPE_STRIP && step && page_last) ||
                     (out_valid && out_ready && out_last);
  end
endmodule

// File: rtl/sss_checker.sv
module sss_checker #(
  parameter int LEN_W = 8,
  parameter int CNT_W = 5,
  parameter int IDX_W = 4,
  localparam int POS_W = LEN_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic             mode,
  input logic [LEN_W-1:0] chunk_len,
  input logic [CNT_W-1:0] chunk_num,
  input logic             in_ready,
  input logic             out_valid,
  input logic [7:0]       out_data,
  input logic             out_ready,
  input logic             done,
  input logic [POS_W-1:0] pos,
  input logic [IDX_W-1:0] chunk
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_PAD_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    mode && pos >= {1'b0, chunk_len} |-> !in_ready); // R5
  AST_POS_RANGE: assert property (@(posedge clk) disable iff (rst)
    pos <= {1'b0, chunk_len} + POS_W'(3)); // R9
  AST_CHUNK_RANGE: assert property (@(posedge clk) disable iff (rst)
    CNT_W'(chunk) < chunk_num); // R9
endmodule

bind spare_status_shaper sss_checker #(.LEN_W(LEN_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .mode(mode), .chunk_len(chunk_len), .chunk_num(chunk_num),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_ready(out_ready), .done(done), .pos(pos), .chunk(chunk)
);

// File: tb/sim_spare_status_shaper.sv
module sim_spare_status_shaper;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode = 1'b0;
  logic [7:0] chunk_len = 8'd4;
  logic [4:0] chunk_num = 5'd1;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b0;
  logic       done;
  logic [3:0] stat_idx = 4'd0;
  logic [7:0] stat_byte;

  int vectors = 0;
  int misses  = 0;
  int seed    = 7;
  logic [7:0] exp_stat [16];

  always #10 clk = ~clk;

  spare_status_shaper u0 (
    .clk(clk), .rst(rst), .mode(mode), .chunk_len(chunk_len), .chunk_num(chunk_num),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .done(done), .stat_idx(stat_idx), .stat_byte(stat_byte)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit coin(input bit en);
    seed = seed * 1103515245 + 12345;
    return en && (((seed >>> 16) & 3) == 0);
  endfunction

  task automatic run_page(input bit md, input int len, input int num,
                          input bit st_in, input bit st_out, input string tag);
    logic [7:0] in_q [$];
    logic [7:0] exp_q [$];
    int  ipos = 0, ichunk = 0, icnt = 0, ocnt = 0, total, cyc = 0;
    bit  exp_done = 0, fin = 0, held = 0;
    logic [7:0] held_data = 8'h00;
    mode = md; chunk_len = 8'(len); chunk_num = 5'(num);
    for (int n = 0; n < num; n++) begin
      if (!md) begin
        for (int p = 0; p < len + 4; p++)
          in_q.push_back(p < len ? 8'(n * 16 + p + 1) :
                         p == len ? 8'(8'hC0 + n) : 8'(8'hE0 + p));
      end else begin
        for (int p = 0; p < len; p++) in_q.push_back(8'(n * 8 + p + 8'h31));
      end
    end
    total = md ? num * (len + 4) : num * len;
    while (!fin) begin
      @(negedge clk);
      cyc++;
      chk({tag, " R7 R8 done timing"}, int'(done), int'(exp_done));
      if (exp_done) fin = 1;
      exp_done = 0;
      if (held) begin
        chk({tag, " R6 hold valid"}, int'(out_valid), 1);
        chk({tag, " R6 hold data"}, int'(out_data), int'(held_data));
      end
      in_valid  = in_q.size() > 0 && !coin(st_in);
      in_data   = in_q.size() > 0 ? in_q[0] : 8'h00;
      out_ready = !coin(st_out);
      #1;
      held = out_valid && !out_ready;
      held_data = out_data;
      if (in_valid && in_ready) begin
        logic [7:0] b = in_q.pop_front();
        if (!md) begin
          if (ipos < len) exp_q.push_back(b);
          if (ipos == len) exp_stat[ichunk] = b;
          if (ipos == len + 3) begin
            ipos = 0;
            if (ichunk == num - 1) exp_done = 1;
            ichunk++;
          end else ipos++;
        end else begin
          exp_q.push_back(b);
          icnt++;
          if (icnt % len == 0) for (int z = 0; z < 4; z++) exp_q.push_back(8'h00);
        end
      end
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) chk({tag, " R2 R5 extra output"}, int'(out_data), -1);
        else chk({tag, md ? " R4 insert byte" : " R1 strip byte"},
                 int'(out_data), int'(exp_q.pop_front()));
        ocnt++;
        if (md && ocnt == total) exp_done = 1;
      end
      if (cyc > 20000) begin
        chk({tag, " watchdog"}, 0, 1);
        fin = 1;
      end
    end
    in_valid = 1'b0;
    chk({tag, " R2 R5 leftover expected bytes"}, exp_q.size(), 0);
  endtask

  task automatic read_stat(input int num, input string tag);
    for (int n = 0; n < num; n++) begin
      @(negedge clk);
      stat_idx = 4'(n);
      @(negedge clk);
      chk({tag, " R3 status entry"}, int'(stat_byte), int'(exp_stat[n]));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R10 out_valid after reset", int'(out_valid), 0);
    chk("R10 done after reset", int'(done), 0);
    chk("R10 in_ready after reset", int'(in_ready), 1);
    run_page(0, 6, 3, 0, 0, "strip full rate");
    read_stat(3, "strip full rate");
    run_page(0, 5, 16, 1, 1, "strip stalls 16 chunks");
    run_page(0, 3, 2, 1, 0, "R9 back-to-back strip");
    read_stat(2, "R9 back-to-back strip");
    run_page(0, 1, 1, 0, 1, "strip len1");
    read_stat(1, "strip len1");
    run_page(1, 4, 2, 1, 1, "insert stalls");
    run_page(1, 1, 1, 0, 0, "insert len1");
    run_page(1, 7, 16, 0, 1, "R9 insert 16 chunks");
    run_page(0, 2, 4, 1, 1, "strip after insert");
    read_stat(4, "strip after insert");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    #3000000;
    misses++;
    vectors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule